// File: doc/BRIEF.md
# Configurable Trigger Condition Detector

This block turns a small set of trigger sources into a single trigger signal. There are two external pins. Pin 0 is the input-side pin and pin 1 is the output-side pin. There are also two internal strobes, one from the ADC capture path and one from the logic analyzer. A 20-bit configuration word picks the condition type or types for each external pin: low level, high level, any edge, rising edge or falling edge. It also gates each of the four sources with its own enable bit.

The external pins are asynchronous. Each one passes through a two-flop synchroniser before it is evaluated. Edges are found by comparing the synchronised value with its value one cycle earlier. The internal strobes are already in the clock domain, so they go straight into the merge. The result is registered once.

Edge conditions give a one-cycle strobe. Level conditions give an output that stays high while the level holds. With an all-zero configuration, which is the reset state that a bus register would load, no trigger is ever produced.

Top module: `trig_cond_detect`

## Requirements
- R1: While reset is asserted, and in every cycle in which the configuration word is all zero, `trig_o` is 0 one cycle later.
- R2: A change on an external pin that is set up before clock edge k can first affect `trig_o` after edge k+2. This is two synchroniser stages plus the output register.
- R3: Bit p of the configuration (bits 1:0) selects low-level detection for pin p. `trig_o` is high in every cycle in which the synchronised pin is 0.
- R4: Bits 3:2 select high-level detection for pins 0 and 1. `trig_o` is high in every cycle in which the synchronised pin is 1.
- R5: Bits 5:4 select any-edge detection. Every transition of the synchronised pin gives exactly one cycle of `trig_o`.
- R6: Bits 7:6 select rising-edge detection. Only 0-to-1 transitions give a one-cycle `trig_o`.
- R7: Bits 9:8 select falling-edge detection. Only 1-to-0 transitions give a one-cycle `trig_o`.
- R8: Bit 16 enables pin 0 and bit 17 enables pin 1. When a pin's enable bit is clear, its condition bits have no effect on `trig_o`.
- R9: Bit 18 enables the ADC strobe. When it is set, `adc_trig_i` high before an edge makes `trig_o` high after that edge, with no synchronisation.
- R10: Bit 19 enables the logic-analyzer strobe, with the same one-cycle timing as R9.
- R11: `trig_o` is the OR of all enabled sources. A pin's result is the OR of every condition type selected for it.
- R12: Reset clears both the synchroniser stages and the edge history. After reset, a pin that was high before reset and stays low gives no falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_pin_i | input | NUM_PINS (2) | Asynchronous external trigger pins |
| adc_trig_i | input | 1 | ADC trigger strobe, synchronous to clk |
| la_trig_i | input | 1 | Logic-analyzer trigger strobe, synchronous to clk |
| cfg_i | input | 20 | Condition selects (bits 9:0) and source enables (bits 19:16) |
| trig_o | output | 1 | Registered trigger |

## Verification
A wrong synchroniser or history value shows up as a trigger that is moved by a whole cycle. It can also show up as a missing or extra edge pulse. Either one appears at `trig_o` no later than three cycles after the pin moves. A history register that keeps its value through reset shows up as a false falling-edge pulse in the first cycles after reset is released. Because every configuration subset is swept against a cycle-accurate model of the pin path, any fault of this kind is caught in the cycle where it first occurs.

// File: rtl/trig_cond_pkg.sv
// Package: shared constants and condition-kind encoding for the trigger
// detector. The kind index k selects configuration field k, which holds
// one bit per pin: bit k*NUM_PINS + pin.
package trig_cond_pkg;

    typedef enum logic [2:0] {
        CK_LOW  = 3'd0,
        CK_HIGH = 3'd1,
        CK_ANY  = 3'd2,
        CK_RISE = 3'd3,
        CK_FALL = 3'd4
    } cond_kind_e;

    localparam int NUM_KINDS = 5;
    localparam int EN_BASE   = 16;

endpackage

// File: rtl/trig_pin_sync.sv
// Module: trig_pin_sync
// Two-flop synchroniser for one asynchronous pin, followed by a history
// flop that holds the synchronised value of the previous cycle.
// Assumes: synchronous active-low reset clears all three flops to 0.
module trig_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic prev_o
);

    logic meta_q;
    logic sync_q;
    logic hist_q;

    // Purpose: capture the pin, re-sample it, and keep last cycle's value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            hist_q <= 1'b0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign level_o = sync_q;
    assign prev_o  = hist_q;

    // R2: synchronised level is the pin as sampled two edges earlier
    assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (level_o == $past(pin_i, 2)));

    // R12: reset leaves no synchronised or historical value behind
    assert_reset_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (level_o == 1'b0 && prev_o == 1'b0));

endmodule

// File: rtl/trig_pin_eval.sv
// Module: trig_pin_eval
// Combinational condition check for one pin. The result is the OR of all
// selected condition kinds, evaluated on the current synchronised level
// and its previous-cycle value.
// Assumes: sel_i is indexed by trig_cond_pkg::cond_kind_e.
module trig_pin_eval
    import trig_cond_pkg::*;
(
    input  logic                 level_i,
    input  logic                 prev_i,
    input  logic [NUM_KINDS-1:0] sel_i,
    output logic                 hit_o
);

    logic [NUM_KINDS-1:0] cond;

    // Purpose: compute each condition kind from the level and its history.
    always_comb begin
        cond          = '0;
        cond[CK_LOW]  = !level_i;
        cond[CK_HIGH] = level_i;
        cond[CK_ANY]  = level_i ^ prev_i;
        cond[CK_RISE] = level_i & !prev_i;
        cond[CK_FALL] = !level_i & prev_i;
    end

    assign hit_o = |(cond & sel_i);

endmodule

// File: rtl/trig_cond_detect.sv
// Module: trig_cond_detect (top)
// Merges NUM_PINS external pins (each synchronised and checked against its
// selected conditions) with ADC and logic-analyzer strobes. Every source is
// gated by its own enable. The merged result is registered once.
// Assumes: NUM_KINDS*NUM_PINS <= EN_BASE, so condition fields and enables
// do not overlap. adc_trig_i and la_trig_i are synchronous to clk.
module trig_cond_detect
    import trig_cond_pkg::*;
#(
    parameter  int NUM_PINS = 2,
    localparam int CFG_W    = EN_BASE + NUM_PINS + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] trig_pin_i,
    input  logic                adc_trig_i,
    input  logic                la_trig_i,
    input  logic [CFG_W-1:0]    cfg_i,
    output logic                trig_o
);

    localparam int COND_W     = NUM_KINDS * NUM_PINS;
    localparam int ADC_EN_BIT = EN_BASE + NUM_PINS;
    localparam int LA_EN_BIT  = EN_BASE + NUM_PINS + 1;

    logic [NUM_PINS-1:0] pin_hit;
    logic [NUM_PINS-1:0] pin_en;
    logic                merged;
    logic                trig_q;

    assign pin_en = cfg_i[EN_BASE +: NUM_PINS];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic                 level;
        logic                 prev;
        logic [NUM_KINDS-1:0] sel;

        // Purpose: gather this pin's select bit from each condition field.
        always_comb begin
            for (int k = 0; k < NUM_KINDS; k++) begin
                sel[k] = cfg_i[k*NUM_PINS + p];
            end
        end

        trig_pin_sync u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (trig_pin_i[p]),
            .level_o (level),
            .prev_o  (prev)
        );

        trig_pin_eval u_eval (
            .level_i (level),
            .prev_i  (prev),
            .sel_i   (sel),
            .hit_o   (pin_hit[p])
        );
    end

    if (COND_W < EN_BASE) begin : g_gap
        logic cfg_gap_unused;
        assign cfg_gap_unused = ^cfg_i[EN_BASE-1:COND_W];
    end

    // Purpose: OR together every enabled source.
    always_comb begin
        merged = |(pin_hit & pin_en)
               | (cfg_i[ADC_EN_BIT] & adc_trig_i)
               | (cfg_i[LA_EN_BIT]  & la_trig_i);
    end

    // Purpose: register the merged trigger once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
        end else begin
            trig_q <= merged;
        end
    end

    assign trig_o = trig_q;

    // R1: an all-zero configuration never yields a trigger
    assert_idle_cfg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i == '0) |=> !trig_o);

    // R8: with every source disabled the output stays low
    assert_no_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i[EN_BASE +: NUM_PINS + 2] == '0) |=> !trig_o);

    // R9: enabled ADC strobe appears one cycle later
    assert_adc_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i[ADC_EN_BIT] && adc_trig_i) |=> trig_o);

    // R10: enabled logic-analyzer strobe appears one cycle later
    assert_la_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i[LA_EN_BIT] && la_trig_i) |=> trig_o);

endmodule

// File: tb/trig_cond_detect_tb.sv
// Bench: drives input patterns on the falling edge. It keeps its own
// record of the pin values sampled at the last four edges and computes
// the expected trigger from the requirements, checking each cycle.
module trig_cond_detect_tb_top;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pin = 2'b00;
    logic        adc = 1'b0;
    logic        la = 1'b0;
    logic [19:0] cfg = '0;
    logic        trig_o;

    int checks = 0;
    int errors = 0;

    // pin values sampled at edges k, k-1, k-2, k-3
    logic [1:0] ph1 = '0, ph2 = '0, ph3 = '0, ph4 = '0;

    always #(PERIOD/2) clk = ~clk;

    trig_cond_detect dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_pin_i (pin),
        .adc_trig_i (adc),
        .la_trig_i  (la),
        .cfg_i      (cfg),
        .trig_o     (trig_o)
    );

    // expected trigger from requirements R3..R11; s = level, h = previous level
    function automatic logic expect_trig(input logic [19:0] c, input logic [1:0] s,
                                         input logic [1:0] h, input logic a, input logic l);
        logic r = 1'b0;
        for (int i = 0; i < 2; i++) begin
            logic hit;
            hit = (c[i]   & ~s[i])          // low level, bits 1:0
                | (c[2+i] &  s[i])          // high level, bits 3:2
                | (c[4+i] & (s[i] ^ h[i]))  // any edge, bits 5:4
                | (c[6+i] &  s[i] & ~h[i])  // rising, bits 7:6
                | (c[8+i] & ~s[i] &  h[i]); // falling, bits 9:8
            r |= hit & c[16+i];
        end
        r |= (c[18] & a) | (c[19] & l);
        return r;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: trig_o=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: drive, clock, update history, compare against model
    task automatic step(input logic r, input logic [1:0] p, input logic a,
                        input logic l, input logic [19:0] c, input string tag);
        logic e;
        @(negedge clk);
        rst_n = r; pin = p; adc = a; la = l; cfg = c;
        @(posedge clk);
        if (!r) begin
            ph1 = '0; ph2 = '0; ph3 = '0; ph4 = '0;
            e = 1'b0;
        end else begin
            ph4 = ph3; ph3 = ph2; ph2 = ph1; ph1 = p;
            e = expect_trig(c, ph3, ph4, a, l);
        end
        #2;
        check(trig_o, e, tag);
    endtask

    initial begin : watchdog
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] pat0 = 16'b0110_1110_0100_1011;
        logic [15:0] pat1 = 16'b1011_0001_1101_0110;
        string kind_tag[5] = '{"R3", "R4", "R5", "R6", "R7"};

        // R1: reset state, and an all-zero configuration with moving pins
        for (int i = 0; i < 3; i++) step(1'b0, 2'b11, 1'b1, 1'b1, 20'hFFFFF, "R1");
        for (int i = 0; i < 16; i++)
            step(1'b1, {pat1[i], pat0[i]}, pat0[i], pat1[i], 20'h0, "R1");

        // R3..R7: each condition kind alone on each pin, with its enable set
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 5; k++) begin
                logic [19:0] c = (20'd1 << (2*k + p)) | (20'd1 << (16 + p));
                for (int i = 0; i < 20; i++)
                    step(1'b1, {pat1[i%16], pat0[(i+3)%16]}, 1'b0, 1'b0, c, kind_tag[k]);
            end
        end

        // R8: all condition bits set, both pin enables clear
        for (int i = 0; i < 20; i++)
            step(1'b1, {pat0[i%16], pat1[i%16]}, 1'b0, 1'b0, 20'h003FF, "R8");

        // R9: ADC strobe only
        for (int i = 0; i < 20; i++)
            step(1'b1, {pat1[i%16], pat0[i%16]}, pat0[(i+5)%16], 1'b1, 20'h403FF, "R9");

        // R10: logic-analyzer strobe only
        for (int i = 0; i < 20; i++)
            step(1'b1, {pat1[i%16], pat0[i%16]}, 1'b1, pat1[(i+2)%16], 20'h803FF, "R10");

        // R11: every subset of condition kinds, combined sources
        for (int s = 0; s < 32; s++) begin
            logic [19:0] c = '0;
            for (int k = 0; k < 5; k++) begin
                c[2*k]     = s[k];
                c[2*k + 1] = ~s[k];
            end
            c[16] = 1'b1; c[17] = s[1]; c[18] = s[0]; c[19] = s[2];
            for (int i = 0; i < 24; i++)
                step(1'b1, {pat0[(i+s)%16], pat1[(i+2*s)%16]},
                     pat1[(i+7)%16], pat0[(i+11)%16], c, "R11");
        end

        // R2: rising edge on pin 0, latency counted explicitly
        for (int i = 0; i < 4; i++) step(1'b1, 2'b00, 1'b0, 1'b0, 20'h10040, "R2");
        step(1'b1, 2'b01, 1'b0, 1'b0, 20'h10040, "R2");   // edge k
        check(trig_o, 1'b0, "R2");
        step(1'b1, 2'b01, 1'b0, 1'b0, 20'h10040, "R2");   // edge k+1
        check(trig_o, 1'b0, "R2");
        step(1'b1, 2'b01, 1'b0, 1'b0, 20'h10040, "R2");   // edge k+2
        check(trig_o, 1'b1, "R2");
        step(1'b1, 2'b01, 1'b0, 1'b0, 20'h10040, "R2");   // edge k+3
        check(trig_o, 1'b0, "R2");

        // R12: pin high, reset while it drops, falling edge must not appear
        for (int i = 0; i < 5; i++) step(1'b1, 2'b01, 1'b0, 1'b0, 20'h10100, "R12");
        step(1'b0, 2'b00, 1'b0, 1'b0, 20'h10100, "R12");
        step(1'b0, 2'b00, 1'b0, 1'b0, 20'h10100, "R12");
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 2'b00, 1'b0, 1'b0, 20'h10100, "R12");
            check(trig_o, 1'b0, "R12");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule